// File: doc/BRIEF.md
# Task-File Register Bank with Two-Deep Address History

This block is the host-visible register file of a disk-style storage device. It supports both 28-bit and 48-bit block addressing. The host reaches it over a plain synchronous register bus: a 4-bit address, read and write strobes, 16-bit write data, and registered read data.

The feature, sector-count and three block-address byte registers each keep two values, the newest write and the one before it. A 48-bit address therefore fits in byte-wide registers: the older value carries the upper half, the newer value carries the lower half. A high-order-byte select bit in the control register picks which value a read returns. Any write to a command-block register clears that bit again.

The control register also holds a software reset bit and an active-low interrupt enable. The block gates the interrupt line to the host, qualifies the 16-bit data port with the data-request flag, and loads the final block address when a command completes. It also reports whether a software reset pulse was long enough to count.

Top module: `tfile_bank`

## Requirements
- R1: A host write to a history register (addresses 1 to 5) moves that register's newest byte into its older slot and stores the written low byte as the newest.
- R2: While the high-order-byte select (control bit 7) is 0, reads of addresses 1 to 5 return the newest byte. While it is 1, they return the older byte. The read data appear on `bus_rdata` one cycle after the read strobe, with the upper byte zero.
- R3: Any host write to addresses 0 to 7 clears the high-order-byte select to 0. Reads never change it.
- R4: A write to address 8 sets select from bit 7, software reset from bit 2 and interrupt disable from bit 1. A read of address 8 returns {8'h00, select, 3'b000, 1'b1, reset, disable, 1'b0}.
- R5: While the software reset bit is 1, `dev_reset` is high from the next cycle on. The history registers and the device register are held at their defaults: newest sector count 8'h01, newest low address byte 8'h01, every other slot 8'h00. Any pending interrupt is dropped.
- R6: `rst_done` pulses for one cycle, two cycles after software reset is cleared, only if the bit stayed set for at least SRST_MIN_CYC cycles (5 us at CLK_MHZ). A shorter pulse produces no `rst_done`.
- R7: `host_irq` is high only when an interrupt is pending, device register bit 4 equals DEV_ID, and the disable bit is 0. It rises two cycles after a `dev_irq_set` pulse.
- R8: A pending interrupt is cleared by a `dev_irq_clr` pulse or by a host write to the command register (address 7).
- R9: A read of address 0 returns the device-loaded data word while `drq` is 1, and 0 while `drq` is 0. A host write to address 0 while `drq` is 1 gives a one-cycle `host_wr_valid` with the word. While `drq` is 0 the write is dropped and no pulse appears.
- R10: A `cmd_done` pulse loads the three address registers with `done_lba` bytes 0..2 as newest and bytes 3..5 as older. It loads the sector count with `done_count[7:0]` as newest and `[15:8]` as older.
- R11: A host write to address 7 gives a one-cycle `cmd_valid` with the written low byte on `cmd_code` in the next cycle.
- R12: A read of address 6 returns the last byte written to the device register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| drq | input | 1 | Data-request status flag |
| dev_data_load | input | 1 | Device loads the data port |
| dev_data | input | 16 | Word loaded by the device |
| host_wr_valid | output | 1 | Host data word accepted |
| host_wr_data | output | 16 | Host data word |
| cmd_valid | output | 1 | Command byte written |
| cmd_code | output | 8 | Command byte |
| cmd_done | input | 1 | Command completion, load final address |
| done_lba | input | 48 | Final block address |
| done_count | input | 16 | Final sector count |
| dev_irq_set | input | 1 | Device raises an interrupt |
| dev_irq_clr | input | 1 | Device drops a pending interrupt |
| host_irq | output | 1 | Gated interrupt to the host |
| dev_reset | output | 1 | Device held in reset |
| rst_done | output | 1 | Reset pulse of valid width released |

## Verification
A history slot that failed to shift, or a select bit that stayed set after a command-block write, shows up at the first read of an address register, one cycle after the strobe. A bad mask or selection term in the interrupt path shows on `host_irq` within two cycles of the pending flag or the control write. A miscounted reset width shows only at the release: `rst_done` is missing or spurious two cycles after the bit clears. The bench therefore brackets the threshold with pulses one cycle short and exactly long enough.

// File: rtl/tfile_pkg.sv
package tfile_pkg;
  localparam int ADDR_W    = 4;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 16;
  localparam int NUM_HIST  = 5;
  localparam int HX_FEAT   = 0;
  localparam int HX_CNT    = 1;
  localparam int HX_LBA0   = 2;
  localparam int LBA_BYTES = 3;
  localparam int LBA_W     = 2 * LBA_BYTES * BYTE_W;
  localparam int CNT_W     = 2 * BYTE_W;

  localparam int CTL_HOB   = 7;
  localparam int CTL_ONE   = 3;
  localparam int CTL_SRST  = 2;
  localparam int CTL_NIEN  = 1;
  localparam int DEVH_SEL  = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA = 4'd0,
    A_FEAT = 4'd1,
    A_CNT  = 4'd2,
    A_LBA0 = 4'd3,
    A_LBA1 = 4'd4,
    A_LBA2 = 4'd5,
    A_DEVH = 4'd6,
    A_CMD  = 4'd7,
    A_CTL  = 4'd8
  } tf_addr_e;

  // Power-on / soft-reset value of the newest slot of a history register.
  function automatic logic [BYTE_W-1:0] hist_default(input int idx);
    return (idx == HX_CNT || idx == HX_LBA0) ? BYTE_W'(1) : '0;
  endfunction
endpackage

// File: rtl/tfile_hist_reg.sv
module tfile_hist_reg #(
  parameter int           W       = 8,
  parameter logic [W-1:0] CUR_DEF = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_byte,
  input  logic         ld_en,
  input  logic [W-1:0] ld_cur,
  input  logic [W-1:0] ld_prev,
  output logic [W-1:0] cur_q,
  output logic [W-1:0] prev_q
);
  // Priority: reset/soft reset, then completion load, then host write.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cur_q  <= CUR_DEF;
      prev_q <= '0;
    end else if (ld_en) begin
      cur_q  <= ld_cur;
      prev_q <= ld_prev;
    end else if (wr_en) begin
      prev_q <= cur_q;
      cur_q  <= wr_byte;
    end
  end
endmodule

// File: rtl/tfile_ctl.sv
module tfile_ctl #(
  parameter int MIN_CYC = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_ctl,
  input  logic wr_cmdblk,
  input  logic w_hob,
  input  logic w_srst,
  input  logic w_nien,
  output logic hob_q,
  output logic srst_q,
  output logic nien_q,
  output logic dev_reset,
  output logic rst_done
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_CYC);

  logic [CW-1:0] held;
  logic          srst_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hob_q     <= 1'b0;
      srst_q    <= 1'b0;
      nien_q    <= 1'b0;
      srst_d    <= 1'b0;
      dev_reset <= 1'b0;
      rst_done  <= 1'b0;
      held      <= '0;
    end else begin
      if (wr_ctl) begin
        hob_q  <= w_hob;
        srst_q <= w_srst;
        nien_q <= w_nien;
      end else if (wr_cmdblk) begin
        hob_q  <= 1'b0;
      end
      srst_d    <= srst_q;
      dev_reset <= srst_q;
      // Saturating count of cycles spent with the reset bit set.
      if (srst_q) begin
        if (held != SAT) held <= held + 1'b1;
      end else begin
        held <= '0;
      end
      rst_done <= !srst_q && srst_d && (held == SAT);
    end
  end
endmodule

// File: rtl/tfile_irq.sv
module tfile_irq (
  input  logic clk,
  input  logic rst,
  input  logic srst,
  input  logic set,
  input  logic clr,
  input  logic selected,
  input  logic nien,
  output logic host_irq
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      if (srst)     pend_q <= 1'b0;
      else if (set) pend_q <= 1'b1;
      else if (clr) pend_q <= 1'b0;
      host_irq <= pend_q && selected && !nien && !srst;
    end
  end
endmodule

// File: rtl/tfile_bank.sv
module tfile_bank
  import tfile_pkg::*;
#(
  parameter int CLK_MHZ     = 250,
  parameter int SRST_MIN_US = 5,
  parameter int DEV_ID      = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              drq,
  input  logic              dev_data_load,
  input  logic [WORD_W-1:0] dev_data,
  output logic              host_wr_valid,
  output logic [WORD_W-1:0] host_wr_data,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_code,
  input  logic              cmd_done,
  input  logic [LBA_W-1:0]  done_lba,
  input  logic [CNT_W-1:0]  done_count,
  input  logic              dev_irq_set,
  input  logic              dev_irq_clr,
  output logic              host_irq,
  output logic              dev_reset,
  output logic              rst_done
);
  localparam int SRST_MIN_CYC = CLK_MHZ * SRST_MIN_US;
  localparam logic DEV_BIT = DEV_ID[0];

  logic hob_q, srst_q, nien_q;
  logic wr_ctl, wr_cmdblk, wr_cmd, selected;
  logic [BYTE_W-1:0] devh_q;
  logic [WORD_W-1:0] data_q;
  logic [NUM_HIST-1:0][BYTE_W-1:0] h_cur, h_prev;
  logic [BYTE_W-1:0] hist_sel;

  assign wr_ctl    = bus_wr && (bus_addr == A_CTL);
  assign wr_cmdblk = bus_wr && (bus_addr <= A_CMD);
  assign wr_cmd    = bus_wr && (bus_addr == A_CMD);
  assign selected  = (devh_q[DEVH_SEL] == DEV_BIT);

  tfile_ctl #(.MIN_CYC(SRST_MIN_CYC)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_ctl    (wr_ctl),
    .wr_cmdblk (wr_cmdblk),
    .w_hob     (bus_wdata[CTL_HOB]),
    .w_srst    (bus_wdata[CTL_SRST]),
    .w_nien    (bus_wdata[CTL_NIEN]),
    .hob_q     (hob_q),
    .srst_q    (srst_q),
    .nien_q    (nien_q),
    .dev_reset (dev_reset),
    .rst_done  (rst_done)
  );

  tfile_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .srst     (srst_q),
    .set      (dev_irq_set),
    .clr      (dev_irq_clr || wr_cmd),
    .selected (selected),
    .nien     (nien_q),
    .host_irq (host_irq)
  );

  for (genvar h = 0; h < NUM_HIST; h++) begin : g_hist
    logic              lde;
    logic [BYTE_W-1:0] ldc, ldp;
    if (h == HX_FEAT) begin : g_feat
      assign lde = 1'b0;
      assign ldc = '0;
      assign ldp = '0;
    end else if (h == HX_CNT) begin : g_cnt
      assign lde = cmd_done;
      assign ldc = done_count[BYTE_W-1:0];
      assign ldp = done_count[CNT_W-1:BYTE_W];
    end else begin : g_lba
      assign lde = cmd_done;
      assign ldc = done_lba[(h-HX_LBA0)*BYTE_W +: BYTE_W];
      assign ldp = done_lba[(h-HX_LBA0+LBA_BYTES)*BYTE_W +: BYTE_W];
    end
    tfile_hist_reg #(.W(BYTE_W), .CUR_DEF(hist_default(h))) u_reg (
      .clk     (clk),
      .rst     (rst),
      .clr     (srst_q),
      .wr_en   (bus_wr && (bus_addr == ADDR_W'(h + 1))),
      .wr_byte (bus_wdata[BYTE_W-1:0]),
      .ld_en   (lde),
      .ld_cur  (ldc),
      .ld_prev (ldp),
      .cur_q   (h_cur[h]),
      .prev_q  (h_prev[h])
    );
  end

  always_comb begin
    hist_sel = '0;
    for (int i = 0; i < NUM_HIST; i++)
      if (bus_addr == ADDR_W'(i + 1)) hist_sel = hob_q ? h_prev[i] : h_cur[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      devh_q        <= '0;
      data_q        <= '0;
      host_wr_valid <= 1'b0;
      host_wr_data  <= '0;
      cmd_valid     <= 1'b0;
      cmd_code      <= '0;
      bus_rdata     <= '0;
    end else begin
      if (srst_q)                              devh_q <= '0;
      else if (bus_wr && bus_addr == A_DEVH)   devh_q <= bus_wdata[BYTE_W-1:0];
      if (dev_data_load) data_q <= dev_data;
      host_wr_valid <= bus_wr && (bus_addr == A_DATA) && drq;
      if (bus_wr && bus_addr == A_DATA && drq) host_wr_data <= bus_wdata;
      cmd_valid <= wr_cmd;
      if (wr_cmd) cmd_code <= bus_wdata[BYTE_W-1:0];
      if (bus_rd) begin
        case (bus_addr)
          A_DATA:  bus_rdata <= drq ? data_q : '0;
          A_FEAT, A_CNT, A_LBA0, A_LBA1, A_LBA2:
                   bus_rdata <= {{(WORD_W-BYTE_W){1'b0}}, hist_sel};
          A_DEVH:  bus_rdata <= {{(WORD_W-BYTE_W){1'b0}}, devh_q};
          A_CTL:   bus_rdata <= {{(WORD_W-BYTE_W){1'b0}}, hob_q, 3'b000,
                                 1'b1, srst_q, nien_q, 1'b0};
          default: bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tfile_bank_chk.sv
module tfile_bank_chk
  import tfile_pkg::*;
#(
  parameter int MIN_CYC = 1250
) (
  input logic                            clk,
  input logic                            rst,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic                            bus_wr,
  input logic                            bus_rd,
  input logic [WORD_W-1:0]               bus_wdata,
  input logic [WORD_W-1:0]               bus_rdata,
  input logic                            drq,
  input logic                            cmd_done,
  input logic                            hob_q,
  input logic                            srst_q,
  input logic                            nien_q,
  input logic                            selected,
  input logic                            host_irq,
  input logic                            dev_reset,
  input logic                            rst_done,
  input logic [NUM_HIST-1:0][BYTE_W-1:0] h_cur,
  input logic [NUM_HIST-1:0][BYTE_W-1:0] h_prev
);
  // Independent measure of the last software reset run length.
  int  chk_len;
  logic chk_prev;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_len  <= 0;
      chk_prev <= 1'b0;
    end else begin
      chk_prev <= srst_q;
      if (srst_q && !chk_prev)                chk_len <= 1;
      else if (srst_q && chk_len < MIN_CYC)   chk_len <= chk_len + 1;
    end
  end

  p_hist_shift_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_LBA0 && !srst_q && !cmd_done) |=>
      (h_prev[HX_LBA0] == $past(h_cur[HX_LBA0]) &&
       h_cur[HX_LBA0] == $past(bus_wdata[BYTE_W-1:0])));

  p_hob_read_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_LBA0 && hob_q) |=>
      (bus_rdata == {8'h00, $past(h_prev[HX_LBA0])}));

  p_hob_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr <= A_CMD) |=> !hob_q);

  p_srst_hold_r5: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> dev_reset);

  p_srst_default_r5: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> (h_cur[HX_CNT] == 8'h01 && h_prev[HX_LBA0] == 8'h00 && !host_irq));

  p_rst_width_r6: assert property (@(posedge clk) disable iff (rst)
    rst_done |-> (chk_len >= MIN_CYC && !srst_q));

  p_rst_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rst_done |=> !rst_done);

  p_irq_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (nien_q || !selected) |=> !host_irq);

  p_data_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_DATA && !drq) |=> (bus_rdata == '0));
endmodule

bind tfile_bank tfile_bank_chk #(.MIN_CYC(SRST_MIN_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .drq       (drq),
  .cmd_done  (cmd_done),
  .hob_q     (hob_q),
  .srst_q    (srst_q),
  .nien_q    (nien_q),
  .selected  (selected),
  .host_irq  (host_irq),
  .dev_reset (dev_reset),
  .rst_done  (rst_done),
  .h_cur     (h_cur),
  .h_prev    (h_prev)
);

// File: tb/test_tfile_bank.sv
module test_tfile_bank;
  localparam int MIN = 250 * 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        drq = 1'b0, dev_data_load = 1'b0;
  logic [15:0] dev_data = '0;
  logic        host_wr_valid, cmd_valid;
  logic [15:0] host_wr_data;
  logic [7:0]  cmd_code;
  logic        cmd_done = 1'b0;
  logic [47:0] done_lba = '0;
  logic [15:0] done_count = '0;
  logic        dev_irq_set = 1'b0, dev_irq_clr = 1'b0;
  logic        host_irq, dev_reset, rst_done;

  tfile_bank i_tfile_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .drq(drq),
    .dev_data_load(dev_data_load), .dev_data(dev_data),
    .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_done(cmd_done),
    .done_lba(done_lba), .done_count(done_count),
    .dev_irq_set(dev_irq_set), .dev_irq_clr(dev_irq_clr),
    .host_irq(host_irq), .dev_reset(dev_reset), .rst_done(rst_done)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int n_done = 0, n_hwr = 0, n_cmd = 0;
  logic [15:0] last_hwr = '0;
  logic [7:0]  last_cmd = '0;

  typedef struct { logic [15:0] exp; string tag; } exp_t;
  exp_t sb[$];
  logic rd_q = 1'b0;

  always @(posedge clk) begin
    rd_q <= bus_rd;
    if (rst_done) n_done++;
    if (host_wr_valid) begin n_hwr++; last_hwr = host_wr_data; end
    if (cmd_valid) begin n_cmd++; last_cmd = cmd_code; end
  end

  // Monitor: pops the expected read word one cycle after the strobe.
  always @(negedge clk) begin
    if (rd_q) begin
      exp_t e;
      n_chk++;
      if (sb.size() == 0) begin
        n_err++;
        $display("FAIL read without expectation: actual %h expected none", bus_rdata);
      end else begin
        e = sb.pop_front();
        if (bus_rdata !== e.exp) begin
          n_err++;
          $display("FAIL %s: actual %h expected %h", e.tag, bus_rdata, e.exp);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Tasks start and end at a falling edge.
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sb.push_back(e);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(1);

    // Reset state
    rd(4'd2, 16'h0001, "R5 reset default count");
    rd(4'd3, 16'h0001, "R5 reset default lba low");
    rd(4'd8, 16'h0008, "R4 control readback after reset");
    chk(host_irq == 1'b0, "R7 irq low after reset", host_irq, 0);

    // History and high-order select
    wr(4'd3, 16'h0011);
    wr(4'd3, 16'h0022);
    rd(4'd3, 16'h0022, "R1 newest slot");
    wr(4'd8, 16'h0080);
    rd(4'd3, 16'h0011, "R2 older slot with select");
    rd(4'd8, 16'h0088, "R4 select bit readback, R3 read keeps it");
    wr(4'd4, 16'h0033);
    rd(4'd8, 16'h0008, "R3 select cleared by register write");
    rd(4'd3, 16'h0022, "R2 newest slot after clear");
    rd(4'd4, 16'h0033, "R1 mid byte write");

    // Interrupt gating
    wr(4'd6, 16'h0000);
    dev_irq_set = 1'b1; wait_n(1); dev_irq_set = 1'b0;
    wait_n(2);
    chk(host_irq == 1'b1, "R7 irq raised when selected and enabled", host_irq, 1);
    wr(4'd8, 16'h0002);
    wait_n(2);
    chk(host_irq == 1'b0, "R7 irq masked by disable bit", host_irq, 0);
    rd(4'd8, 16'h000A, "R4 disable bit readback");
    wr(4'd8, 16'h0000);
    wait_n(2);
    chk(host_irq == 1'b1, "R7 irq back when enabled", host_irq, 1);
    wr(4'd6, 16'h0010);
    wait_n(2);
    chk(host_irq == 1'b0, "R7 irq masked when not selected", host_irq, 0);
    rd(4'd6, 16'h0010, "R12 device register readback");
    wr(4'd6, 16'h0000);
    wait_n(2);
    chk(host_irq == 1'b1, "R7 irq back when selected", host_irq, 1);
    dev_irq_clr = 1'b1; wait_n(1); dev_irq_clr = 1'b0;
    wait_n(2);
    chk(host_irq == 1'b0, "R8 irq cleared by device clear", host_irq, 0);
    dev_irq_set = 1'b1; wait_n(1); dev_irq_set = 1'b0;
    wait_n(2);
    chk(host_irq == 1'b1, "R7 irq raised again", host_irq, 1);
    wr(4'd7, 16'h00EC);
    wait_n(2);
    chk(host_irq == 1'b0, "R8 irq cleared by command write", host_irq, 0);
    chk(n_cmd == 1 && last_cmd == 8'hEC, "R11 command pulse", {n_cmd[15:0], 8'h0, last_cmd}, 32'h000100EC);

    // Data port
    dev_data = 16'hBEEF; dev_data_load = 1'b1; wait_n(1); dev_data_load = 1'b0;
    rd(4'd0, 16'h0000, "R9 data read masked without drq");
    drq = 1'b1;
    rd(4'd0, 16'hBEEF, "R9 data read with drq");
    drq = 1'b0;
    wr(4'd0, 16'h1234);
    wait_n(2);
    chk(n_hwr == 0, "R9 host data write dropped without drq", n_hwr, 0);
    drq = 1'b1;
    wr(4'd0, 16'h5678);
    wait_n(2);
    drq = 1'b0;
    chk(n_hwr == 1 && last_hwr == 16'h5678, "R9 host data write accepted", {n_hwr[15:0], last_hwr}, 32'h00015678);

    // Completion load
    done_lba = 48'h665544332211; done_count = 16'hA0B0;
    cmd_done = 1'b1; wait_n(1); cmd_done = 1'b0;
    rd(4'd3, 16'h0011, "R10 lba byte 0");
    rd(4'd4, 16'h0022, "R10 lba byte 1");
    rd(4'd5, 16'h0033, "R10 lba byte 2");
    rd(4'd2, 16'h00B0, "R10 count low");
    wr(4'd8, 16'h0080);
    rd(4'd3, 16'h0044, "R10 lba byte 3");
    rd(4'd5, 16'h0066, "R10 lba byte 5");
    rd(4'd2, 16'h00A0, "R10 count high");

    // Short software reset
    dev_irq_set = 1'b1; wait_n(1); dev_irq_set = 1'b0;
    wr(4'd8, 16'h0004);
    wait_n(3);
    chk(dev_reset == 1'b1, "R5 device held in reset", dev_reset, 1);
    chk(host_irq == 1'b0, "R5 pending irq dropped", host_irq, 0);
    rd(4'd5, 16'h0000, "R5 lba high default during reset");
    rd(4'd2, 16'h0001, "R5 count default during reset");
    wr(4'd8, 16'h0000);
    wait_n(4);
    chk(n_done == 0, "R6 short reset not recognised", n_done, 0);
    chk(dev_reset == 1'b0, "R5 device released", dev_reset, 0);
    chk(host_irq == 1'b0, "R5 irq stays dropped after release", host_irq, 0);

    // Threshold: one cycle short, then exact
    wr(4'd8, 16'h0004);
    wait_n(MIN - 2);
    wr(4'd8, 16'h0000);
    wait_n(4);
    chk(n_done == 0, "R6 reset one cycle short", n_done, 0);
    wr(4'd8, 16'h0004);
    wait_n(MIN - 1);
    wr(4'd8, 16'h0000);
    wait_n(4);
    chk(n_done == 1, "R6 reset of minimum width recognised", n_done, 1);
    rd(4'd8, 16'h0008, "R4 control after reset release");

    wait_n(3);
    if (sb.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    summary();
    $finish;
  end
endmodule